// File: doc/BRIEF.md
# Watchdog Timer with Power-Fail Flag

This block is a supervisory watchdog. A free-running counter advances once per prescaler tick. Software restarts it with a kick strobe. If no kick arrives before the count reaches the limit picked by a 3-bit timeout code, the block drives a reset pulse of fixed width. Eight timeout codes select tick limits from a parameter table. These limits are not a smooth progression, and one code turns the watchdog off. All limits are parameters, so a simulation can use short periods while silicon uses the real ones.

Next to the timer sits a volatile flag. Software reads it after a reset to tell a power-loss reset from a watchdog reset. A digital low-voltage-detect input clears the flag. A write to the control register loads the flag with a new value. The watchdog's own reset pulse never touches the flag.

Top module: `supv_watchdog`

## Requirements
- R1: The timeout code `wd_sel_i` selects a tick limit. The default limits are 100, 45, 15, off, 6000, 2000, 1000 and 500 ticks for codes 0 through 7. After a restart, the pulse goes high in the cycle after the edge that carries the limit-th tick.
- R2: The count advances only on cycles where `tick_i` is 1. While `tick_i` is 0 the count is frozen, and no pulse results.
- R3: A cycle with `kick_i` = 1 returns the count to zero.
- R4: Any change of `wd_sel_i` from its value in the previous cycle returns the count to zero.
- R5: Code 3'b011 holds the count at zero and never starts a pulse. The next enabled code counts from zero.
- R6: Each pulse on `wdt_rst_o` lasts PULSE_W cycles (default 4). The count restarts at the moment of the timeout, so with no kick the pulses repeat every limit ticks.
- R7: While `rst_n` is low, `pf_flag_o` is 0 and `wdt_rst_o` is 0.
- R8: A cycle with `lvd_i` = 1 clears `pf_flag_o` to 0 at the next edge.
- R9: A cycle with `cfg_wr_i` = 1 and `lvd_i` = 0 loads `cfg_flag_i` into `pf_flag_o`. When `lvd_i` and `cfg_wr_i` are both 1, the flag becomes 0.
- R10: With neither `lvd_i` nor `cfg_wr_i` active, the flag holds its value, including across watchdog pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| kick_i | input | 1 | Watchdog restart strobe |
| wd_sel_i | input | 3 | Timeout code from the control register |
| lvd_i | input | 1 | Low-voltage detect, active high |
| cfg_wr_i | input | 1 | Control-register write strobe |
| cfg_flag_i | input | 1 | Flag value carried by the write |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| pf_flag_o | output | 1 | Power-fail flag (0 after a power failure) |

## Verification
A wrong count or a missed restart shows up at `wdt_rst_o` as a pulse that comes a few cycles early or late. For the longest code, that error can take up to 6000 ticks to appear. The bench therefore measures the latency from each restart to the pulse edge exactly, rather than only noting whether a pulse happened. A wrong flag state appears on `pf_flag_o` one cycle after the stimulus. A stale code register causes a missed restart when the code changes. That fault is caught by switching codes partway through a count.

// File: rtl/wdg_pkg.sv
// Package: shared constants and helpers for the watchdog block.
// Assumes a table of exactly eight timeout entries, one per 3-bit code.
package wdg_pkg;
    localparam logic [2:0] CODE_OFF = 3'b011;

    typedef int unsigned tmo_tab_t [8];

    // Largest entry of the timeout table; used to size the counter.
    function automatic int unsigned tab_max(input tmo_tab_t t);
        int unsigned m;
        m = 1;
        for (int i = 0; i < 8; i++) begin
            if (t[i] > m) m = t[i];
        end
        return m;
    endfunction
endpackage

// File: rtl/wdg_limit_sel.sv
// Module: maps the 3-bit timeout code to a tick limit and a disable flag.
// Assumes every enabled entry is at least 1; the entry of the off code is unused.
module wdg_limit_sel #(
    parameter wdg_pkg::tmo_tab_t TMO_TICKS = '{100, 45, 15, 0, 6000, 2000, 1000, 500},
    parameter int CNT_W = 13
) (
    input  logic [2:0]       sel_i,
    output logic [CNT_W-1:0] lim_o,
    output logic             dis_o
);
    logic [CNT_W-1:0] tab [8];

    // One constant entry per code.
    for (genvar g = 0; g < 8; g++) begin : g_tab
        assign tab[g] = CNT_W'(TMO_TICKS[g]);
    end

    // Pick the entry for the current code.
    assign lim_o = tab[sel_i];
    assign dis_o = (sel_i == wdg_pkg::CODE_OFF);
endmodule

// File: rtl/wdg_tick_cnt.sv
// Module: tick counter with restart on kick or code change; flags the timeout.
// Assumes lim_i >= 1 whenever dis_i is low.
module wdg_tick_cnt #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [2:0]       sel_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             dis_i,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       sel_q;
    logic             sel_chg;
    logic             restart;
    logic             at_lim;

    assign sel_chg = (sel_i != sel_q);
    assign restart = kick_i | sel_chg;
    assign at_lim  = tick_i && (cnt_q == lim_i - CNT_W'(1));
    assign fire_o  = !dis_i && !restart && at_lim;

    // Remember last cycle's code so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= wdg_pkg::CODE_OFF;
        else        sel_q <= sel_i;
    end

    // Count ticks; clear when off, on restart or at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (dis_i || restart || fire_o) cnt_q <= '0;
        else if (tick_i)                     cnt_q <= cnt_q + CNT_W'(1);
    end

    p_cnt_below_lim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_i && !sel_chg) |-> (cnt_q < lim_i));
    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart && !dis_i) |=> $stable(cnt_q));
    p_kick_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (cnt_q == '0));
    p_chg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (cnt_q == '0));
    p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_pulse.sv
// Module: stretches a one-cycle timeout strobe into a reset pulse of PULSE_W cycles.
// Assumes PULSE_W >= 1; a new strobe reloads the width.
module wdg_pulse #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int PW_W = $clog2(PULSE_W + 1);

    logic [PW_W-1:0] left_q;

    // Load on a timeout, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (fire_i)         left_q <= PW_W'(PULSE_W);
        else if (left_q != '0)   left_q <= left_q - PW_W'(1);
    end

    assign pulse_o = (left_q != '0);

    p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o);
    p_pulse_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> !$past(fire_i));
endmodule

// File: rtl/wdg_pf_flag.sv
// Module: volatile power-fail flag; low-voltage detect clears it, a register write loads it.
// Assumes lvd_i is already synchronous to clk.
module wdg_pf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lvd_i,
    input  logic wr_i,
    input  logic wr_val_i,
    output logic flag_o
);
    logic flag_q;

    // Low voltage beats a write; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (lvd_i) flag_q <= 1'b0;
        else if (wr_i)  flag_q <= wr_val_i;
    end

    assign flag_o = flag_q;

    p_lvd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_i |=> !flag_o);
    p_wr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !lvd_i) |=> (flag_o == $past(wr_val_i)));
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !lvd_i) |=> $stable(flag_o));
endmodule

// File: rtl/supv_watchdog.sv
// Module: top of the watchdog with power-fail flag.
// Assumes all inputs are synchronous to clk; tick_i comes from an external prescaler.
module supv_watchdog #(
    parameter wdg_pkg::tmo_tab_t TMO_TICKS = '{100, 45, 15, 0, 6000, 2000, 1000, 500},
    parameter int PULSE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic [2:0] wd_sel_i,
    input  logic       lvd_i,
    input  logic       cfg_wr_i,
    input  logic       cfg_flag_i,
    output logic       wdt_rst_o,
    output logic       pf_flag_o
);
    localparam int CNT_W = $clog2(wdg_pkg::tab_max(TMO_TICKS) + 1);

    logic [CNT_W-1:0] lim;
    logic             dis;
    logic             fire;

    wdg_limit_sel #(.TMO_TICKS(TMO_TICKS), .CNT_W(CNT_W)) u_sel (
        .sel_i (wd_sel_i),
        .lim_o (lim),
        .dis_o (dis)
    );

    wdg_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .kick_i (kick_i),
        .sel_i  (wd_sel_i),
        .lim_i  (lim),
        .dis_i  (dis),
        .fire_o (fire)
    );

    wdg_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pulse_o (wdt_rst_o)
    );

    wdg_pf_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvd_i    (lvd_i),
        .wr_i     (cfg_wr_i),
        .wr_val_i (cfg_flag_i),
        .flag_o   (pf_flag_o)
    );

    p_rst_quiet_r7: assert property (@(posedge clk)
        !rst_n |=> (!wdt_rst_o && !pf_flag_o));
endmodule

// File: tb/supv_watchdog_tb_top.sv
module supv_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;

    typedef struct packed {
        logic [2:0]  code;
        int unsigned lim;
    } vec_t;

    // Code sequence; neighbours differ so each step is a code change.
    localparam vec_t VEC [7] = '{
        '{3'b010, 15}, '{3'b001, 45}, '{3'b000, 100}, '{3'b111, 500},
        '{3'b110, 1000}, '{3'b101, 2000}, '{3'b100, 6000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       kick_i = 1'b0;
    logic [2:0] wd_sel_i = 3'b011;
    logic       lvd_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic       cfg_flag_i = 1'b0;
    logic       wdt_rst_o;
    logic       pf_flag_o;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supv_watchdog dut_i (
        .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .kick_i (kick_i),
        .wd_sel_i (wd_sel_i), .lvd_i (lvd_i), .cfg_wr_i (cfg_wr_i),
        .cfg_flag_i (cfg_flag_i), .wdt_rst_o (wdt_rst_o), .pf_flag_o (pf_flag_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the pulse is seen; -1 if bound is exceeded.
    task automatic measure(input int start, input int bound, output int lat);
        lat = start;
        forever begin
            @(negedge clk);
            lat++;
            if (wdt_rst_o) break;
            if (lat >= bound) begin
                lat = -1;
                break;
            end
        end
    endtask

    // Run n cycles and return how many samples showed the pulse.
    task automatic idle(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_o) hits++;
        end
    endtask

    task automatic wait_low();
        while (wdt_rst_o) @(negedge clk);
    endtask

    task automatic cfg_write(input logic v, input logic lvd);
        cfg_wr_i = 1'b1; cfg_flag_i = v; lvd_i = lvd;
        @(negedge clk);
        cfg_wr_i = 1'b0; lvd_i = 1'b0;
    endtask

    initial begin
        int lat;
        int hits;
        int w;
        repeat (3) @(negedge clk);
        chk("R7 reset pulse", int'(wdt_rst_o), 0);
        chk("R7 reset flag", int'(pf_flag_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: write sets flag; it must survive every watchdog pulse (R10).
        cfg_write(1'b1, 1'b0);
        chk("R9 write 1", int'(pf_flag_o), 1);

        // Table: timeout per code, pulse width, and for the first entry the period.
        for (int k = 0; k < 7; k++) begin
            wd_sel_i = VEC[k].code;
            measure(0, int'(VEC[k].lim) + 20, lat);
            chk($sformatf("R1 latency code %0d", VEC[k].code), lat, int'(VEC[k].lim) + 1);
            w = 0;
            while (wdt_rst_o) begin
                w++;
                @(negedge clk);
            end
            chk("R6 pulse width", w, PW);
            if (k == 0) begin
                measure(PW, int'(VEC[k].lim) + 20, lat);
                chk("R6 repeat period", lat, int'(VEC[k].lim));
                wait_low();
            end
        end
        chk("R10 flag kept over pulses", int'(pf_flag_o), 1);

        // R3: kick partway through the count restarts it.
        wd_sel_i = 3'b010;
        idle(10, hits);
        chk("R3 no pulse before kick", hits, 0);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        measure(1, 60, lat);
        chk("R3 latency after kick", lat, 16);
        wait_low();

        // R4: code change partway through restarts with the new limit.
        wd_sel_i = 3'b001;
        @(negedge clk);
        wd_sel_i = 3'b010;
        idle(10, hits);
        wd_sel_i = 3'b001;
        measure(0, 100, lat);
        chk("R4 latency after code change", lat, 46);
        wait_low();

        // R2: no ticks, no progress.
        tick_i = 1'b0;
        wd_sel_i = 3'b000;
        idle(150, hits);
        chk("R2 no pulse without ticks", hits, 0);
        tick_i = 1'b1;
        measure(0, 200, lat);
        chk("R2 latency after ticks resume", lat, 100);
        wait_low();

        // R5: off code never pulses; re-enable counts from zero.
        wd_sel_i = 3'b011;
        idle(300, hits);
        chk("R5 no pulse when off", hits, 0);
        wd_sel_i = 3'b111;
        measure(0, 600, lat);
        chk("R5 latency after re-enable", lat, 501);
        wait_low();
        wd_sel_i = 3'b011;

        // Flag directed cases.
        idle(20, hits);
        chk("R10 flag holds idle", int'(pf_flag_o), 1);
        lvd_i = 1'b1;
        @(negedge clk);
        lvd_i = 1'b0;
        chk("R8 lvd clears flag", int'(pf_flag_o), 0);
        cfg_write(1'b1, 1'b0);
        chk("R9 write 1 again", int'(pf_flag_o), 1);
        cfg_write(1'b1, 1'b1);
        chk("R9 lvd wins over write", int'(pf_flag_o), 0);
        cfg_write(1'b1, 1'b0);
        cfg_write(1'b0, 1'b0);
        chk("R9 write 0 clears", int'(pf_flag_o), 0);
        cfg_write(1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 reset clears flag", int'(pf_flag_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule